// File: doc/BRIEF.md
# Four-Channel DMA Register Controller

This block holds the programming state of a four-channel, byte-wide DMA engine and steps it through the transfers. A host reaches it over a small I/O port bus: a 4-bit port offset plus read and write strobes. Through that bus it loads a 16-bit start offset and a 16-bit transfer count for each channel, sets per-channel modes, masks and software requests, and reads back the current offsets, counts and a status byte. A separate write port loads a 4-bit page value per channel. The page forms bits 19:16 of the 20-bit memory address.

Devices raise request lines. Each cycle the block looks at the requests (hardware or software) of the channels that are not masked, and grants the lowest-numbered one. For one cycle it then drives a one-hot acknowledge, the 20-bit address, the transfer type of that channel and a terminal-count flag. At the same edge it steps the channel's current offset and count. When a channel's count runs out, the block sets that channel's status flag. It then either reloads the channel from its base values (auto-initialisation) or masks the channel.

Top module: `dmac_top`

## Requirements
- R1: After reset every channel is masked, the status byte reads 0x00, all current offsets and counts read 0, and no acknowledge is driven.
- R2: Every 16-bit register is reached through two byte accesses at the same port, low byte first. One flip-flop, shared by ports 0x0–0x7, selects the byte and toggles on every read or write to those ports. Any write to port 0xC returns it to the low byte.
- R3: A write to port 2n loads both the base offset and the current offset of channel n, and a write to port 2n+1 loads both its base count and current count. Reads of these ports return the current values.
- R4: Port 0xA changes one mask: bits 1:0 pick the channel and bit 2 sets (1) or clears (0) its mask. Any write to port 0xE clears all four masks. A write to port 0xF loads mask n from data bit n.
- R5: A channel is eligible when its request line or its software request is high and it is unmasked. The lowest-numbered eligible channel is granted. Its acknowledge bit is high for exactly one cycle, the cycle after the request is seen, and no grant is made while an acknowledge is high.
- R6: During a transfer the address output is {page, current offset} of the granted channel. Afterwards the offset goes up by one when mode bit 5 is 1 and down by one when it is 0, wrapping within 16 bits without changing the page.
- R7: Each transfer decrements the current count. A transfer made with a count of 0 is the terminal one: the terminal-count output is high together with its acknowledge, and status bit n (for channel n) is set. A programmed count c therefore gives c+1 transfers.
- R8: On a terminal transfer, a channel whose mode bit 4 is 0 becomes masked. A channel whose mode bit 4 is 1 reloads its current offset and count from the base values and stays unmasked.
- R9: A read of port 0x8 returns terminal-count flags in bits 3:0 and pending requests (request line or software request, mask ignored) in bits 7:4, and the read clears the terminal-count flags.
- R10: A write to port 0x9 sets (bit 2 = 1) or clears (bit 2 = 0) the software request of the channel in bits 1:0. A software request is cleared when its channel is granted.
- R11: When bit 2 of the command register (port 0x8 write) is 1, no channel is granted. Writing it back to 0 resumes grants.
- R12: Any write to port 0xD returns all controller state to its reset values. Page registers are not affected.
- R13: A write to port 0xB sets the mode of the channel in bits 1:0. Bits 3:2 (transfer type) appear on the type output during that channel's transfers, bit 4 enables auto-initialisation and bit 5 selects the offset direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Port write strobe, one cycle per byte |
| io_rd | input | 1 | Port read strobe, one cycle per byte |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid while io_rd is high |
| pg_wr | input | 1 | Page register write strobe |
| pg_sel | input | 2 | Channel whose page is written |
| pg_data | input | 4 | Page value (address bits 19:16) |
| dreq | input | 4 | Device request per channel |
| dack | output | 4 | One-hot acknowledge, one cycle per transfer |
| mem_addr | output | 20 | Address of the current transfer |
| xfer_type | output | 2 | Transfer type of the granted channel |
| xfer_tc | output | 1 | High when the current transfer is terminal |

## Verification
The bench accesses one port with a single byte and then reads another port without clearing the flip-flop. A per-port pointer, or one that only toggles on writes, would return the wrong byte. It runs an offset down from 0x0001 through 0x0000 to 0xFFFF, and another up from 0xFFFF. A carry or borrow leaking into the page would show up on the upper four address bits. Terminal count is checked at count 0 in both auto-initialised and one-shot mode. A design that ends one transfer early, or masks an auto-initialised channel, loses or gains acknowledges. Status reads are issued twice in a row, so flags that clear on reading appear once only. Software requests are set and cleared while the channel is masked, so their pending bits can be seen without a transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH    = 4;   // port map decodes channel in two bits
  localparam int CHW    = 2;
  localparam int OFS_W  = 16;
  localparam int PG_W   = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       inc;
    logic       auto_init;
    logic [1:0] xtype;
  } chan_mode_t;

  function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] a, input logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  function automatic logic [OFS_W-1:0] next_cnt(input logic [OFS_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic cnt_expires(input logic [OFS_W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [OFS_W-1:0] put_byte(input logic [OFS_W-1:0] old,
                                                input logic [BYTE_W-1:0] b, input logic hi);
    return hi ? {b, old[BYTE_W-1:0]} : {old[OFS_W-1:BYTE_W], b};
  endfunction
endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] grant
);
  // lowest index wins: descending scan, last hit stays
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en && req[i]) grant = N'(1) << i;
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = OFS_W,
  parameter int PW = PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              wr_ofs,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              mode_we,
  input  chan_mode_t        mode_in,
  input  logic              page_we,
  input  logic [PW-1:0]     page_in,
  input  logic              step,
  output logic [AW-1:0]     cur_ofs,
  output logic [AW-1:0]     cur_cnt,
  output logic [PW+AW-1:0]  phys,
  output chan_mode_t        mode,
  output logic              tc_hit
);
  logic [AW-1:0] base_ofs, base_cnt;
  logic [PW-1:0] page_q;
  logic          reload;

  assign tc_hit = step && cnt_expires(cur_cnt);
  assign reload = tc_hit && mode.auto_init;
  assign phys   = {page_q, cur_ofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_ofs <= '0; cur_ofs <= '0; base_cnt <= '0; cur_cnt <= '0; mode <= '0;
    end else if (mclr) begin
      base_ofs <= '0; cur_ofs <= '0; base_cnt <= '0; cur_cnt <= '0; mode <= '0;
    end else begin
      if (mode_we) mode <= mode_in;
      if (wr_ofs) begin
        base_ofs <= put_byte(base_ofs, wbyte, hi_sel);
        cur_ofs  <= put_byte(base_ofs, wbyte, hi_sel);
      end else if (step) begin
        cur_ofs <= reload ? base_ofs : next_ofs(cur_ofs, mode.inc);
      end
      if (wr_cnt) begin
        base_cnt <= put_byte(base_cnt, wbyte, hi_sel);
        cur_cnt  <= put_byte(base_cnt, wbyte, hi_sel);
      end else if (step) begin
        cur_cnt <= reload ? base_cnt : next_cnt(cur_cnt);
      end
    end
  end

  // page lives outside the controller proper: master clear leaves it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_we) page_q <= page_in;
  end

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tc_hit && !wr_cnt && !mclr) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && mode.auto_init && !wr_cnt && !wr_ofs && !mclr)
      |=> (cur_cnt == $past(base_cnt) && cur_ofs == $past(base_ofs)));
  // R6
  ofs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode.inc && !reload && cur_ofs == '1 && !wr_ofs && !mclr) |=> (cur_ofs == '0));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int AW = OFS_W,
  parameter int PW = PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [3:0]        io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic              pg_wr,
  input  logic [CHW-1:0]    pg_sel,
  input  logic [PW-1:0]     pg_data,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    dack,
  output logic [PW+AW-1:0]  mem_addr,
  output logic [1:0]        xfer_type,
  output logic              xfer_tc
);
  localparam int FW = PW + AW;

  // port offsets
  localparam logic [3:0] P_STAT = 4'h8, P_REQ = 4'h9, P_SMSK = 4'hA, P_MODE = 4'hB;
  localparam logic [3:0] P_BPCL = 4'hC, P_MCLR = 4'hD, P_MCLA = 4'hE, P_MALL = 4'hF;

  logic             bptr, ctl_off;
  logic [NCH-1:0]   mask_q, swreq_q, tc_q, dack_q;
  logic [FW-1:0]    addr_q;
  logic [1:0]       type_q;
  logic             tcout_q;

  logic [AW-1:0]    ofs_a [NCH];
  logic [AW-1:0]    cnt_a [NCH];
  logic [FW-1:0]    phys_a[NCH];
  chan_mode_t       mode_a[NCH];
  logic [NCH-1:0]   tc_hit_v, auto_v, grant, eligible, pending, tc_evt;

  logic             reg_acc, mclr, stat_rd;
  logic [CHW-1:0]   sel_ch;
  logic [FW-1:0]    addr_mux;
  logic [1:0]       type_mux;

  assign reg_acc  = (io_wr || io_rd) && !io_addr[3];
  assign mclr     = io_wr && io_addr == P_MCLR;
  assign stat_rd  = io_rd && io_addr == P_STAT;
  assign sel_ch   = io_wdata[CHW-1:0];
  assign pending  = dreq | swreq_q;
  assign eligible = pending & ~mask_q;
  assign tc_evt   = tc_hit_v;

  dmac_arb #(.N(NCH)) arb_i (
    .req(eligible), .en(!ctl_off && dack_q == '0), .grant(grant)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan #(.AW(AW), .PW(PW)) chan_i (
      .clk(clk), .rst_n(rst_n), .mclr(mclr),
      .wr_ofs(io_wr && !io_addr[3] && io_addr[2:1] == CHW'(g) && !io_addr[0]),
      .wr_cnt(io_wr && !io_addr[3] && io_addr[2:1] == CHW'(g) &&  io_addr[0]),
      .hi_sel(bptr), .wbyte(io_wdata),
      .mode_we(io_wr && io_addr == P_MODE && sel_ch == CHW'(g)),
      .mode_in(chan_mode_t'(io_wdata[5:2])),
      .page_we(pg_wr && pg_sel == CHW'(g)), .page_in(pg_data),
      .step(grant[g]),
      .cur_ofs(ofs_a[g]), .cur_cnt(cnt_a[g]), .phys(phys_a[g]),
      .mode(mode_a[g]), .tc_hit(tc_hit_v[g])
    );
    assign auto_v[g] = mode_a[g].auto_init;
  end

  always_comb begin
    addr_mux = '0;
    type_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        addr_mux |= phys_a[i];
        type_mux |= mode_a[i].xtype;
      end
    end
  end

  // read path: byte pointer picks the half of the current value
  always_comb begin
    logic [AW-1:0] v;
    v = io_addr[0] ? cnt_a[io_addr[2:1]] : ofs_a[io_addr[2:1]];
    if (!io_addr[3])             io_rdata = bptr ? v[AW-1:BYTE_W] : v[BYTE_W-1:0];
    else if (io_addr == P_STAT)  io_rdata = {pending, tc_q};
    else                         io_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bptr <= 1'b0; ctl_off <= 1'b0; mask_q <= '1; swreq_q <= '0; tc_q <= '0;
      dack_q <= '0; addr_q <= '0; type_q <= '0; tcout_q <= 1'b0;
    end else begin
      dack_q  <= grant;
      addr_q  <= addr_mux;
      type_q  <= type_mux;
      tcout_q <= |tc_evt;
      if (mclr) begin
        bptr <= 1'b0; ctl_off <= 1'b0; mask_q <= '1; swreq_q <= '0; tc_q <= '0;
      end else begin
        if (io_wr && io_addr == P_BPCL) bptr <= 1'b0;
        else if (reg_acc)               bptr <= ~bptr;
        if (io_wr && io_addr == P_STAT) ctl_off <= io_wdata[2];
        begin : mask_upd
          logic [NCH-1:0] m;
          m = mask_q;
          if (io_wr && io_addr == P_SMSK) m[sel_ch] = io_wdata[2];
          if (io_wr && io_addr == P_MCLA) m = '0;
          if (io_wr && io_addr == P_MALL) m = io_wdata[NCH-1:0];
          mask_q <= m | (tc_evt & ~auto_v);
        end
        begin : req_upd
          logic [NCH-1:0] s;
          s = swreq_q;
          if (io_wr && io_addr == P_REQ) s[sel_ch] = io_wdata[2];
          swreq_q <= s & ~grant;
        end
        tc_q <= (stat_rd ? '0 : tc_q) | tc_evt;
      end
    end
  end

  assign dack      = dack_q;
  assign mem_addr  = addr_q;
  assign xfer_type = type_q;
  assign xfer_tc   = tcout_q;

  // R5
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0) |=> (dack_q == '0));
  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dack_q));
  // R11
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_off |=> (dack_q == '0));
  // R2
  bptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P_BPCL) |=> !bptr);
  // R8
  tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_evt & ~auto_v) != '0) |=> ((mask_q & $past(tc_evt & ~auto_v)) == $past(tc_evt & ~auto_v)));
  // R9
  tc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_evt == '0 && !mclr) |=> (tc_q == '0));
endmodule

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        pg_wr = 1'b0;
  logic [1:0]  pg_sel = '0;
  logic [3:0]  pg_data = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [19:0] mem_addr;
  logic [1:0]  xfer_type;
  logic        xfer_tc;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_top dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pg_wr(pg_wr), .pg_sel(pg_sel),
    .pg_data(pg_data), .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
    .xfer_type(xfer_type), .xfer_tc(xfer_tc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic prd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic w16(input logic [3:0] a, input logic [15:0] v);
    pwr(4'hC, 8'h00); pwr(a, v[7:0]); pwr(a, v[15:8]);
  endtask

  task automatic r16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    pwr(4'hC, 8'h00); prd(a, lo); prd(a, hi);
    v = {hi, lo};
  endtask

  task automatic set_page(input logic [1:0] ch, input logic [3:0] p);
    @(negedge clk); pg_wr = 1'b1; pg_sel = ch; pg_data = p;
    @(negedge clk); pg_wr = 1'b0;
  endtask

  // waits for the next acknowledge and checks the transfer it carries
  task automatic want_xfer(input string tag, input logic [3:0] e_ack, input logic [19:0] e_addr,
                           input logic [1:0] e_type, input logic e_tc);
    bit seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (dack != '0) seen = 1'b1;
    end
    chk(dack == e_ack, {tag, " ack"}, dack, e_ack);
    if (seen) begin
      chk(mem_addr == e_addr, {tag, " addr"}, mem_addr, e_addr);
      chk(xfer_type == e_type, {tag, " R13 type"}, xfer_type, e_type);
      chk(xfer_tc == e_tc, {tag, " R7 tc"}, xfer_tc, e_tc);
    end
  endtask

  task automatic want_quiet(input string tag, input int n);
    logic [3:0] seen = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seen |= dack;
    end
    chk(seen == '0, tag, seen, 0);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [15:0] v;
    chk(dack == '0, "R1 no ack", dack, 0);
    prd(4'h8, b);      chk(b == 8'h00, "R1 status", b, 0);
    r16(4'h0, v);      chk(v == 16'h0, "R1 offset", v, 0);
    r16(4'h7, v);      chk(v == 16'h0, "R1 count", v, 0);
    dreq = 4'b0001;
    want_quiet("R1 masked at reset", 5);
    dreq = '0;
  endtask

  task automatic t_bytes;
    logic [7:0] b; logic [15:0] v;
    w16(4'h2, 16'h1234);
    r16(4'h2, v);      chk(v == 16'h1234, "R3 offset readback", v, 16'h1234);
    w16(4'h3, 16'hBEEF);
    r16(4'h3, v);      chk(v == 16'hBEEF, "R3 count readback", v, 16'hBEEF);
    pwr(4'hC, 8'h00);
    pwr(4'h0, 8'hEE);  // pointer now on high byte, shared across ports
    prd(4'h2, b);      chk(b == 8'h12, "R2 shared pointer", b, 8'h12);
    pwr(4'hC, 8'h55);
    prd(4'h2, b);      chk(b == 8'h34, "R2 clear to low", b, 8'h34);
  endtask

  task automatic t_arb;
    w16(4'h2, 16'h0100); w16(4'h3, 16'h0002); pwr(4'hB, 8'h65); set_page(2'd1, 4'h3);
    w16(4'h4, 16'h0200); w16(4'h5, 16'h0005); pwr(4'hB, 8'h6A);
    pwr(4'hE, 8'h00);
    dreq = 4'b0110;
    want_xfer("R5 low wins", 4'b0010, 20'h30100, 2'd1, 1'b0);
    @(negedge clk);
    chk(dack == '0, "R5 idle cycle", dack, 0);
    want_xfer("R6 inc", 4'b0010, 20'h30101, 2'd1, 1'b0);
    dreq = 4'b0100;
    want_xfer("R5 next chan", 4'b0100, 20'h00200, 2'd2, 1'b0);
    dreq = '0;
    pwr(4'hA, 8'h05);
    dreq = 4'b0110;
    want_xfer("R4 single mask", 4'b0100, 20'h00201, 2'd2, 1'b0);
    dreq = '0;
    pwr(4'hF, 8'h0F);
    dreq = 4'b1111;
    want_quiet("R4 mask all", 6);
    dreq = '0;
  endtask

  task automatic t_oneshot;
    logic [7:0] b;
    w16(4'h6, 16'h0001); w16(4'h7, 16'h0002); pwr(4'hB, 8'h4B); set_page(2'd3, 4'h5);
    pwr(4'hA, 8'h03);
    dreq = 4'b1000;
    want_xfer("R6 dec", 4'b1000, 20'h50001, 2'd2, 1'b0);
    want_xfer("R6 dec zero", 4'b1000, 20'h50000, 2'd2, 1'b0);
    want_xfer("R6 wrap no borrow", 4'b1000, 20'h5FFFF, 2'd2, 1'b1);
    want_quiet("R8 masked after tc", 6);
    prd(4'h8, b);  chk(b == 8'h88, "R9 status tc+pend", b, 8'h88);
    prd(4'h8, b);  chk(b == 8'h80, "R9 tc cleared", b, 8'h80);
    dreq = '0;
  endtask

  task automatic t_auto;
    logic [7:0] b; logic [15:0] v;
    w16(4'h0, 16'hFFFF); w16(4'h1, 16'h0001); pwr(4'hB, 8'h74); set_page(2'd0, 4'hA);
    pwr(4'hA, 8'h00);
    dreq = 4'b0001;
    want_xfer("R6 inc top", 4'b0001, 20'hAFFFF, 2'd1, 1'b0);
    want_xfer("R6 wrap no carry", 4'b0001, 20'hA0000, 2'd1, 1'b1);
    want_xfer("R8 reload", 4'b0001, 20'hAFFFF, 2'd1, 1'b0);
    want_xfer("R8 second tc", 4'b0001, 20'hA0000, 2'd1, 1'b1);
    dreq = '0;
    r16(4'h0, v);  chk(v == 16'hFFFF, "R8 offset reloaded", v, 16'hFFFF);
    r16(4'h1, v);  chk(v == 16'h0001, "R8 count reloaded", v, 16'h0001);
    prd(4'h8, b);  chk(b == 8'h01, "R9 auto tc flag", b, 8'h01);
  endtask

  task automatic t_soft;
    logic [7:0] b;
    pwr(4'h9, 8'h06);
    prd(4'h8, b);  chk(b == 8'h40, "R10 soft set pending", b, 8'h40);
    pwr(4'h9, 8'h02);
    prd(4'h8, b);  chk(b == 8'h00, "R10 soft cleared", b, 8'h00);
    pwr(4'hA, 8'h02);
    pwr(4'h9, 8'h06);
    want_xfer("R10 soft grant", 4'b0100, 20'h00202, 2'd2, 1'b0);
    want_quiet("R10 served once", 6);
  endtask

  task automatic t_disable;
    pwr(4'hA, 8'h01);
    pwr(4'h8, 8'h04);
    dreq = 4'b0010;
    want_quiet("R11 disabled", 6);
    pwr(4'h8, 8'h00);
    want_xfer("R11 resumed", 4'b0010, 20'h30102, 2'd1, 1'b1);
    dreq = '0;
  endtask

  task automatic t_mclr;
    logic [7:0] b; logic [15:0] v;
    pwr(4'hD, 8'h00);
    prd(4'h8, b);  chk(b == 8'h00, "R12 status", b, 0);
    r16(4'h2, v);  chk(v == 16'h0, "R12 offset", v, 0);
    dreq = 4'b1111;
    want_quiet("R12 masks set", 6);
    dreq = '0;
    // page survives: program ch1 again and unmask
    w16(4'h2, 16'h0042); pwr(4'hB, 8'h61); pwr(4'hA, 8'h01);
    dreq = 4'b0010;
    want_xfer("R12 page kept", 4'b0010, 20'h30042, 2'd0, 1'b1);
    dreq = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_bytes;
    t_arb;
    t_oneshot;
    t_auto;
    t_soft;
    t_disable;
    t_mclr;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule